// File: doc/BRIEF.md
# Debug System Bus Access Master

This block gives a debug host direct read and write access to system memory. The host sees a small bank of 32-bit registers: one control/status word, four address words and four data words. Memory accesses are never started by a separate command. They happen as side effects of the register operations themselves: a write to data word 0, a write to address word 0, or a read of data word 0. Each access is a single beat on a simple request port. The port carries an address, write data, a size code and a write enable. It returns read data and an access-fault flag in the same cycle.

An access is 8, 16, 32 or 64 bits wide. A parameter sets the largest width the system supports. The address can step forward by the access size after each access. The step carries through all four 32-bit address words. An error code is latched in the control word and is cleared by writing 1s to it. While any error bit is set, no access is started and the address does not step.

Each register operation is handled in the cycle it is presented. Any memory access it causes is issued combinationally in that same cycle. The results are registered at the next clock edge.

Top module: `sysbus_access_master`

## Requirements
- R1: After reset, all address and data words read 0, the error field reads 0, and the mode bits read 0. No memory request is made until a register operation calls for one.
- R2: The control word has fixed read-only fields. Bits [11:8] are the capability bits: bit 8+i is set when MAX_BITS >= 8<<i. Bits [18:12] hold ADDR_W. Bits [31:29] hold the value 1. When MAX_BITS is 0, the width and version fields read 0.
- R3: Control bits [1:0] hold the size code; codes 0..3 mean 1, 2, 4 and 8 bytes. If an access is called for with a size wider than MAX_BITS, no request is made and the error field is set to 3.
- R4: Writing data word 0 (index 5) while the error is 0 issues one write request. Its address is {address word 1, address word 0}, truncated to ADDR_W bits. For size code 3 the write data is {data word 1, data word 0}; for other codes it is {32'b0, data word 0}.
- R5: After a write request, the address advances by the access size in bytes only when control bit 2 (autoincrement) is set. Otherwise the address is unchanged.
- R6: Each address step adds the access size to the 128-bit value {address word 3, word 2, word 1, word 0}. A carry passes from each word into the next.
- R7: Writing address word 0 (index 1) while the error is 0 and control bit 3 is set issues a read at {address word 1, new value}. Results narrower than 32 bits are zero-extended into data word 0. For size code 3, the upper half goes into data word 1. For other codes, data word 1 keeps its value.
- R8: Reading data word 0 returns the value it held before the read. If the error is 0, the read then steps the address when autoincrement is set. If control bit 4 is set, it also issues a read at the stepped address.
- R9: A read that returns mem_fault sets the error field to 2 and leaves the data words unchanged. mem_fault is not sampled on write requests.
- R10: While the error field is nonzero, no memory request is made and the address does not step. Register words still take written values.
- R11: Writing the control word clears each error bit [6:5] that is written as 1. Error bits written as 0 keep their value.
- R12: A memory request is raised only in a cycle where a register operation is presented, and each operation causes at most one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register operation presented this cycle |
| reg_we | input | 1 | 1 = register write, 0 = register read |
| reg_idx | input | 4 | Register index: 0 control, 1..4 address words 0..3, 5..8 data words 0..3 |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value (current contents, combinational) |
| mem_req | output | 1 | Single-beat memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | Size code of the request |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | 64 | Write data, low-aligned |
| mem_rdata | input | 64 | Read data, valid in the request cycle |
| mem_fault | input | 1 | Access fault for the request, valid in the request cycle |

## Verification
Some properties are checked by assertions on every cycle:
- a latched error blocks every request;
- every request carries a size the configuration supports;
- a faulting read always leaves error code 2;
- a request never appears without a register operation;
- the address holds across a write when autoincrement is off.

Other behaviour can only be shown by the bench's scenarios:
- the exact address arithmetic, including the carry through all four words;
- zero-extension and the split of 64-bit reads;
- the fact that a data-word read returns the old value while it loads a new one;
- the partial clearing of the error field.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_WORDS = 4;
    localparam int unsigned IDX_W     = 4;
    localparam int unsigned ASIZE_W   = 7;

    localparam logic [IDX_W-1:0] IDX_CTRL  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_ADDR0 = 4'd1;
    localparam logic [IDX_W-1:0] IDX_ADDR1 = 4'd2;
    localparam logic [IDX_W-1:0] IDX_ADDR2 = 4'd3;
    localparam logic [IDX_W-1:0] IDX_ADDR3 = 4'd4;
    localparam logic [IDX_W-1:0] IDX_DATA0 = 4'd5;
    localparam logic [IDX_W-1:0] IDX_DATA1 = 4'd6;
    localparam logic [IDX_W-1:0] IDX_DATA2 = 4'd7;
    localparam logic [IDX_W-1:0] IDX_DATA3 = 4'd8;

    localparam logic [1:0] ERR_NONE  = 2'd0;
    localparam logic [1:0] ERR_FAULT = 2'd2;
    localparam logic [1:0] ERR_SIZE  = 2'd3;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [1:0]                size;
        logic                      ainc;
        logic                      rd_on_addr;
        logic                      rd_on_data;
        logic [1:0]                err;
        word_t [NUM_WORDS-1:0]     addr;
        word_t [NUM_WORDS-1:0]     data;
    } sbm_state_t;

endpackage

// File: rtl/sbm_caps.sv
module sbm_caps #(
    parameter int unsigned MAX_BITS = 64
) (
    input  logic [1:0] size_code,
    output logic [3:0] caps,
    output logic       size_ok
);
    for (genvar g = 0; g < 4; g++) begin : g_cap
        assign caps[g] = (MAX_BITS >= (32'd8 << g));
    end

    assign size_ok = caps[size_code];
endmodule

// File: rtl/sbm_addr_inc.sv
module sbm_addr_inc #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] addr_i,
    input  logic [1:0]                       size_code,
    input  logic                             step_en,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] addr_o
);
    logic [WORD_W-1:0]    step;
    logic [NUM_WORDS-1:1] cin;

    assign step = step_en ? (WORD_W'(1) << size_code) : '0;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (g == 0) begin : g_first
            assign {cin[1], addr_o[0]} = {1'b0, addr_i[0]} + {1'b0, step};
        end else if (g == NUM_WORDS - 1) begin : g_last
            assign addr_o[g] = addr_i[g] + WORD_W'(cin[g]);
        end else begin : g_mid
            assign {cin[g+1], addr_o[g]} = {1'b0, addr_i[g]} + {{WORD_W{1'b0}}, cin[g]};
        end
    end
endmodule

// File: rtl/sbm_rdata_fmt.sv
module sbm_rdata_fmt (
    input  logic [63:0] rdata,
    input  logic [1:0]  size_code,
    output logic [31:0] lo_word,
    output logic [31:0] hi_word,
    output logic        hi_load
);
    always_comb begin
        hi_word = rdata[63:32];
        hi_load = 1'b0;
        case (size_code)
            2'd0:    lo_word = {24'b0, rdata[7:0]};
            2'd1:    lo_word = {16'b0, rdata[15:0]};
            2'd2:    lo_word = rdata[31:0];
            default: begin
                lo_word = rdata[31:0];
                hi_load = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sysbus_access_master.sv
module sysbus_access_master
    import sbm_pkg::*;
#(
    parameter int unsigned MAX_BITS = 64,
    parameter int unsigned ADDR_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [3:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_fault
);
    localparam bit                 BUS_ON  = (MAX_BITS > 0);
    localparam logic [2:0]         VER_VAL = BUS_ON ? 3'd1 : 3'd0;
    localparam logic [ASIZE_W-1:0] ASZ_VAL = BUS_ON ? ASIZE_W'(ADDR_W) : '0;

    sbm_state_t s_q, s_d;

    logic [3:0]                       caps;
    logic                             size_ok;
    logic [NUM_WORDS-1:0][WORD_W-1:0] inc_addr;
    logic [31:0]                      rd_lo, rd_hi;
    logic                             rd_hi_load;
    logic                             ainc_en;
    logic                             no_err;
    logic                             acc_go, acc_wr;
    logic [63:0]                      acc_addr;
    logic [31:0]                      wr_lo;

    assign ainc_en = s_q.ainc && BUS_ON;
    assign no_err  = (s_q.err == ERR_NONE);

    sbm_caps #(.MAX_BITS(MAX_BITS)) u_caps (
        .size_code (s_q.size),
        .caps      (caps),
        .size_ok   (size_ok)
    );

    sbm_addr_inc #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_inc (
        .addr_i    (s_q.addr),
        .size_code (s_q.size),
        .step_en   (ainc_en),
        .addr_o    (inc_addr)
    );

    sbm_rdata_fmt u_fmt (
        .rdata     (mem_rdata),
        .size_code (s_q.size),
        .lo_word   (rd_lo),
        .hi_word   (rd_hi),
        .hi_load   (rd_hi_load)
    );

    // next-state and request logic
    always_comb begin
        s_d      = s_q;
        acc_go   = 1'b0;
        acc_wr   = 1'b0;
        acc_addr = {s_q.addr[1], s_q.addr[0]};
        wr_lo    = s_q.data[0];

        if (reg_en && reg_we) begin
            case (reg_idx)
                IDX_CTRL: begin
                    s_d.size       = reg_wdata[1:0];
                    s_d.ainc       = reg_wdata[2];
                    s_d.rd_on_addr = reg_wdata[3];
                    s_d.rd_on_data = reg_wdata[4];
                    s_d.err        = s_q.err & ~reg_wdata[6:5];
                end
                IDX_ADDR0: begin
                    s_d.addr[0] = reg_wdata;
                    if (no_err && s_q.rd_on_addr) begin
                        acc_go   = 1'b1;
                        acc_addr = {s_q.addr[1], reg_wdata};
                    end
                end
                IDX_ADDR1: s_d.addr[1] = reg_wdata;
                IDX_ADDR2: s_d.addr[2] = reg_wdata;
                IDX_ADDR3: s_d.addr[3] = reg_wdata;
                IDX_DATA0: begin
                    s_d.data[0] = reg_wdata;
                    wr_lo       = reg_wdata;
                    if (no_err) begin
                        acc_go = 1'b1;
                        acc_wr = 1'b1;
                    end
                end
                IDX_DATA1: s_d.data[1] = reg_wdata;
                IDX_DATA2: s_d.data[2] = reg_wdata;
                IDX_DATA3: s_d.data[3] = reg_wdata;
                default: ;
            endcase
        end else if (reg_en && (reg_idx == IDX_DATA0) && no_err) begin
            s_d.addr = inc_addr;
            if (s_q.rd_on_data) begin
                acc_go   = 1'b1;
                acc_addr = {inc_addr[1], inc_addr[0]};
            end
        end

        mem_req   = 1'b0;
        mem_we    = acc_wr;
        mem_size  = s_q.size;
        mem_addr  = acc_addr[ADDR_W-1:0];
        mem_wdata = {((s_q.size == 2'd3) ? s_q.data[1] : 32'b0), wr_lo};

        if (acc_go) begin
            if (!size_ok) begin
                s_d.err = ERR_SIZE;
            end else begin
                mem_req = 1'b1;
                if (acc_wr) begin
                    s_d.addr = inc_addr;
                end else if (mem_fault) begin
                    s_d.err = ERR_FAULT;
                end else begin
                    s_d.data[0] = rd_lo;
                    if (rd_hi_load) s_d.data[1] = rd_hi;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            IDX_CTRL: begin
                reg_rdata[1:0]   = s_q.size;
                reg_rdata[2]     = s_q.ainc;
                reg_rdata[3]     = s_q.rd_on_addr;
                reg_rdata[4]     = s_q.rd_on_data;
                reg_rdata[6:5]   = s_q.err;
                reg_rdata[11:8]  = caps;
                reg_rdata[18:12] = ASZ_VAL;
                reg_rdata[31:29] = VER_VAL;
            end
            IDX_ADDR0: reg_rdata = s_q.addr[0];
            IDX_ADDR1: reg_rdata = s_q.addr[1];
            IDX_ADDR2: reg_rdata = s_q.addr[2];
            IDX_ADDR3: reg_rdata = s_q.addr[3];
            IDX_DATA0: reg_rdata = s_q.data[0];
            IDX_DATA1: reg_rdata = s_q.data[1];
            IDX_DATA2: reg_rdata = s_q.data[2];
            IDX_DATA3: reg_rdata = s_q.data[3];
            default:   reg_rdata = '0;
        endcase
    end

    AST_ERR_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err != ERR_NONE) |-> !mem_req); // R10

    AST_LEGAL_SIZE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> caps[mem_size]); // R3

    AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_fault) |=> (s_q.err == ERR_FAULT)); // R9

    AST_REQ_WITH_OP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> reg_en); // R12

    AST_ADDR_HELD_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && (reg_idx == IDX_DATA0) && !s_q.ainc)
        |=> (s_q.addr == $past(s_q.addr))); // R5

endmodule

// File: tb/sysbus_access_master_test.sv
module sysbus_access_master_test;
    import sbm_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;

    logic [31:0] rdata_w, rdata_n;
    logic        req_w, we_w, req_n, we_n;
    logic [1:0]  size_w, size_n;
    logic [63:0] addr_w;
    logic [47:0] addr_n;
    logic [63:0] wdata_w, wdata_n, mrd_w, mrd_n;
    logic        flt_w, flt_n;

    int checks = 0, fails = 0;
    int cnt_w = 0, cnt_n = 0;
    logic [63:0] last_addr_w, last_wdata_w;
    logic [1:0]  last_size_w, last_size_n;
    logic        last_we_w;
    logic [31:0] rv_w, rv_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] memv(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3C3_3C3C, a[31:0] + 32'h0101_0101};
    endfunction

    function automatic logic [31:0] zext(input logic [63:0] v, input int sz);
        case (sz)
            0: return {24'b0, v[7:0]};
            1: return {16'b0, v[15:0]};
            default: return v[31:0];
        endcase
    endfunction

    always_comb begin
        mrd_w = memv(addr_w);
        flt_w = (addr_w[63:60] == 4'hF);
        mrd_n = memv({16'b0, addr_n});
        flt_n = (addr_n[47:44] == 4'hF);
    end

    sysbus_access_master #(.MAX_BITS(64), .ADDR_W(64)) uut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(rdata_w),
        .mem_req(req_w), .mem_we(we_w), .mem_size(size_w), .mem_addr(addr_w),
        .mem_wdata(wdata_w), .mem_rdata(mrd_w), .mem_fault(flt_w)
    );

    sysbus_access_master #(.MAX_BITS(16), .ADDR_W(48)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(rdata_n),
        .mem_req(req_n), .mem_we(we_n), .mem_size(size_n), .mem_addr(addr_n),
        .mem_wdata(wdata_n), .mem_rdata(mrd_n), .mem_fault(flt_n)
    );

    always @(posedge clk) begin
        if (req_w) begin
            cnt_w        <= cnt_w + 1;
            last_addr_w  <= addr_w;
            last_wdata_w <= wdata_w;
            last_size_w  <= size_w;
            last_we_w    <= we_w;
        end
        if (req_n) begin
            cnt_n       <= cnt_n + 1;
            last_size_n <= size_n;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_idx = i; reg_wdata = v;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] i);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_idx = i;
        #1;
        rv_w = rdata_w;
        rv_n = rdata_n;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0]  base, exp_a;
        logic [31:0]  d0, d1;
        logic [63:0]  a;
        int           n, nn;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset contents and fixed fields
        rd(IDX_CTRL);
        check("R1 R2 ctrl wide", rv_w, 64'h2004_0F00);
        check("R1 R2 ctrl narrow", rv_n, 64'h2003_0300);
        for (int i = 1; i <= 8; i++) begin
            rd(4'(i));
            check("R1 word reset", rv_w, 0);
        end
        check("R1 no request", cnt_w, 0);

        // R3 R4 R5: write sweep
        for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 4; k++) begin
                for (int ai = 0; ai < 2; ai++) begin
                    base = {32'h0000_0A00 + 32'(k), 32'h1230_0000 + 32'(k) * 32'h0001_0010};
                    d0 = 32'h8000_0001 ^ (32'(k) << 8) ^ 32'(sz);
                    d1 = 32'h0BAD_0000 | 32'(k * 3 + ai);
                    wr(IDX_CTRL, 32'(sz) | (32'(ai) << 2) | (32'd3 << 5));
                    wr(IDX_ADDR1, base[63:32]);
                    wr(IDX_ADDR0, base[31:0]);
                    wr(IDX_DATA1, d1);
                    n = cnt_w; nn = cnt_n;
                    wr(IDX_DATA0, d0);
                    check("R4 one write", cnt_w, n + 1);
                    check("R4 write addr", last_addr_w, base);
                    check("R3 write size", last_size_w, sz);
                    check("R4 write en", last_we_w, 1);
                    check("R4 write data", last_wdata_w, (sz == 3) ? {d1, d0} : {32'b0, d0});
                    exp_a = base + ((ai != 0) ? (64'd1 << sz) : 64'd0);
                    rd(IDX_ADDR0);
                    check("R5 addr0 after write", rv_w, exp_a[31:0]);
                    rd(IDX_ADDR1);
                    check("R5 addr1 after write", rv_w, exp_a[63:32]);
                    if (sz >= 2) begin
                        check("R3 narrow no request", cnt_n, nn);
                        rd(IDX_CTRL);
                        check("R3 narrow size error", (rv_n >> 5) & 3, 3);
                    end else begin
                        check("R3 narrow request", cnt_n, nn + 1);
                        check("R3 narrow size", last_size_n, sz);
                    end
                end
            end
        end

        // R7: read on address write
        for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 4; k++) begin
                base = {32'h0000_0123 ^ 32'(k), 32'h00F0_0000 + 32'(k) * 32'h1357};
                wr(IDX_CTRL, 32'(sz) | (32'd1 << 3) | (32'd3 << 5));
                wr(IDX_ADDR1, base[63:32]);
                wr(IDX_DATA1, 32'hDEAD_BEEF);
                n = cnt_w;
                wr(IDX_ADDR0, base[31:0]);
                check("R7 one read", cnt_w, n + 1);
                check("R7 read en", last_we_w, 0);
                check("R7 read addr", last_addr_w, base);
                rd(IDX_DATA0);
                check("R7 data0 zext", rv_w, zext(memv(base), sz));
                rd(IDX_DATA1);
                check("R7 data1", rv_w, (sz == 3) ? memv(base) >> 32 : 64'hDEAD_BEEF);
            end
        end

        // R8: read on data with autoincrement
        wr(IDX_CTRL, 32'd2 | (32'd1 << 3) | (32'd3 << 5));
        wr(IDX_ADDR1, 32'h0);
        wr(IDX_ADDR0, 32'h100);
        wr(IDX_CTRL, 32'd2 | (32'd1 << 2) | (32'd1 << 4) | (32'd3 << 5));
        a = 64'h100;
        for (int j = 0; j < 4; j++) begin
            n = cnt_w;
            rd(IDX_DATA0);
            check("R8 returns held data", rv_w, memv(a) & 64'hFFFF_FFFF);
            a = a + 4;
            check("R8 read issued", cnt_w, n + 1);
            check("R8 read at stepped addr", last_addr_w, a);
        end
        rd(IDX_ADDR0);
        check("R8 addr after reads", rv_w, a[31:0]);
        wr(IDX_CTRL, 32'd2 | (32'd1 << 2) | (32'd3 << 5));
        n = cnt_w;
        rd(IDX_DATA0);
        check("R8 held data no rod", rv_w, memv(a) & 64'hFFFF_FFFF);
        rd(IDX_ADDR0);
        check("R8 step without read", rv_w, a[31:0] + 4);
        check("R8 no read without rod", cnt_w, n);

        // R6: carry through four words
        wr(IDX_CTRL, 32'd3 | (32'd1 << 2) | (32'd3 << 5));
        wr(IDX_ADDR3, 32'h0);
        wr(IDX_ADDR2, 32'hFFFF_FFFF);
        wr(IDX_ADDR1, 32'hFFFF_FFFF);
        wr(IDX_ADDR0, 32'hFFFF_FFF8);
        rd(IDX_DATA0);
        rd(IDX_ADDR0); check("R6 carry word0", rv_w, 0);
        rd(IDX_ADDR1); check("R6 carry word1", rv_w, 0);
        rd(IDX_ADDR2); check("R6 carry word2", rv_w, 0);
        rd(IDX_ADDR3); check("R6 carry word3", rv_w, 1);
        wr(IDX_CTRL, 32'd0 | (32'd1 << 2) | (32'd3 << 5));
        wr(IDX_ADDR3, 32'h7);
        wr(IDX_ADDR2, 32'h9);
        wr(IDX_ADDR1, 32'h5);
        wr(IDX_ADDR0, 32'hFFFF_FFFF);
        rd(IDX_DATA0);
        rd(IDX_ADDR0); check("R6 byte step word0", rv_w, 0);
        rd(IDX_ADDR1); check("R6 byte step word1", rv_w, 6);
        rd(IDX_ADDR2); check("R6 byte step word2", rv_w, 9);
        rd(IDX_ADDR3); check("R6 byte step word3", rv_w, 7);

        // R9: faulting read
        wr(IDX_CTRL, 32'd2 | (32'd1 << 3) | (32'd3 << 5));
        wr(IDX_ADDR1, 32'h0);
        wr(IDX_ADDR0, 32'h40);
        wr(IDX_ADDR1, 32'hF000_0000);
        n = cnt_w;
        wr(IDX_ADDR0, 32'h44);
        check("R9 fault request made", cnt_w, n + 1);
        rd(IDX_CTRL);
        check("R9 fault error code", (rv_w >> 5) & 3, 2);
        rd(IDX_DATA0);
        check("R9 data kept on fault", rv_w, memv(64'h40) & 64'hFFFF_FFFF);

        // R10: error blocks activity
        n = cnt_w;
        wr(IDX_ADDR0, 32'h48);
        wr(IDX_DATA0, 32'h5555_AAAA);
        rd(IDX_DATA0);
        check("R10 data stored while error", rv_w, 32'h5555_AAAA);
        wr(IDX_CTRL, 32'd2 | (32'd1 << 2) | (32'd1 << 3) | (32'd1 << 4));
        rd(IDX_DATA0);
        rd(IDX_ADDR0);
        check("R10 no step while error", rv_w, 32'h48);
        check("R10 no request while error", cnt_w, n);

        // R11: write-1-to-clear
        wr(IDX_CTRL, 32'd2 | (32'd1 << 5));
        rd(IDX_CTRL);
        check("R11 clear bit0 keeps 2", (rv_w >> 5) & 3, 2);
        wr(IDX_CTRL, 32'd2 | (32'd1 << 6));
        rd(IDX_CTRL);
        check("R11 clear bit1 gives 0", (rv_w >> 5) & 3, 0);

        // R9: write does not sample fault
        wr(IDX_ADDR0, 32'h50);
        n = cnt_w;
        wr(IDX_DATA0, 32'h1234);
        check("R9 write in fault region issued", cnt_w, n + 1);
        rd(IDX_CTRL);
        check("R9 write ignores fault", (rv_w >> 5) & 3, 0);

        // R11 / R3 on the narrow instance
        wr(IDX_CTRL, 32'd2 | (32'd3 << 5));
        wr(IDX_DATA0, 32'h77);
        rd(IDX_CTRL);
        check("R3 narrow error 3", (rv_n >> 5) & 3, 3);
        wr(IDX_CTRL, 32'd2 | (32'd1 << 5));
        rd(IDX_CTRL);
        check("R11 narrow partial clear", (rv_n >> 5) & 3, 2);
        wr(IDX_CTRL, 32'd2 | (32'd1 << 6));
        rd(IDX_CTRL);
        check("R11 narrow full clear", (rv_n >> 5) & 3, 0);

        // R12: no request without an operation, none from non-data reads
        n = cnt_w;
        rd(IDX_ADDR2);
        repeat (5) begin
            @(negedge clk);
            check("R12 idle no request", req_w, 0);
        end
        check("R12 count unchanged", cnt_w, n);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule